// File: doc/BRIEF.md
# Floppy density and drive-size control

This block sits on the CPU write path of a floppy subsystem that carries two controller cores: one limited to single density and one that handles double density. It watches CPU writes to two control addresses and keeps two modes: the recording density (single or double) and the drive size (5.25-inch or 8-inch). From those modes it enables exactly one controller core, routes that core's drive-side strobes to the drive cable, makes a controller clock strobe, sets the track-43 indication and gates write precompensation.

The modes are held in one four-state machine. The states are `MS_SD5` (single density, 5.25-inch), `MS_SD8` (single, 8-inch), `MS_DD5` (double, 5.25-inch) and `MS_DD8` (double, 8-inch). There are four named transitions. `SEL_DD` is a write of the double-density code and moves SDx to DDx. `SEL_SD` is a write of the single-density code and moves DDx to SDx. `SEL_8` is a size command with the 8-inch bit set and moves xx5 to xx8. `SEL_5` is a size command with that bit clear and moves xx8 to xx5. Any other cycle leaves the state unchanged.

While reset is asserted, the machine loads `MS_SD5` if the size switch reads 1 and `MS_SD8` if it reads 0. Everything runs in one 4 MHz system clock domain. The controller clock is brought out both as a level and as a one-cycle enable strobe.

Top module: `fdc_mode_ctl`

## Requirements
- R1: While `rst_n` is low (synchronous reset), density becomes single. Drive size becomes 5.25-inch when `size_sw` is 1 and 8-inch when it is 0. After reset, `size_sw` has no effect.
- R2: A write (`bus_wr`=1) of 8'hFF to address 16'h37EC selects double density, and a write of 8'hFE to that address selects single density. The new mode shows on the outputs from the next clock edge.
- R3: A write to 16'h37EC with any data other than 8'hFE or 8'hFF leaves the density unchanged. So does a write to any address other than the two control addresses.
- R4: Exactly one of `sd_core_en` and `dd_core_en` is high at all times. `sd_core_en` is high when single density is selected.
- R5: `drv_out` equals `sd_drv` in single density and `dd_drv` in double density. Bit 0 is step, bit 1 is direction, bit 2 is write data and bit 3 is write gate.
- R6: A write to 16'h37EE with data bit 7 = 1 selects 8-inch when bit 6 = 1 and 5.25-inch when bit 6 = 0. A write there with bit 7 = 0 leaves the size unchanged. Size writes never change density, and density writes never change size.
- R7: `ctl_clk_en` pulses for one cycle every 4 system cycles in 5.25-inch mode (1 MHz) and every 2 cycles in 8-inch mode (2 MHz). It only pulses while `ctl_clk` is high, and `ctl_clk` is high for half of each period.
- R8: In 5.25-inch mode `tg43_out` is 1. In 8-inch mode it equals the active core's track-43 input (`sd_tg43` or `dd_tg43`).
- R9: `precomp_en` is 1 only in double density. In that mode it is 1 on every track for 5.25-inch drives, and only when `dd_tg43` is 1 for 8-inch drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| bus_addr | input | 16 | CPU write address |
| bus_wdata | input | 8 | CPU write data |
| size_sw | input | 1 | Size switch, 1 = 5.25-inch, 0 = 8-inch; read during reset |
| sd_drv | input | 4 | Single-density core drive strobes {wgate, wdata, dir, step} |
| dd_drv | input | 4 | Double-density core drive strobes, same order |
| sd_tg43 | input | 1 | Single-density core track-43 indication |
| dd_tg43 | input | 1 | Double-density core track-43 indication |
| sd_core_en | output | 1 | Enable for the single-density core |
| dd_core_en | output | 1 | Enable for the double-density core |
| drv_out | output | 4 | Strobes to the drive, same order |
| tg43_out | output | 1 | Track-43 indication to the clock and precomp logic |
| precomp_en | output | 1 | Write precompensation enable |
| ctl_clk | output | 1 | Controller clock level |
| ctl_clk_en | output | 1 | One-cycle strobe per controller clock period |

## Verification
The bench builds the block with its default parameters: 16-bit address, 8-bit data, a 4-bit drive bus and the two control addresses at 16'h37EC and 16'h37EE. With these defaults, the real density and size codes are reached directly. Random writes that hit the control addresses a third of the time each also reach every transition of the four states, and near-miss codes such as 8'hFD and size commands with bit 7 clear are reached as well. Since all four drive bits are present, a wrong bit routing would show up. The strobe spacing is measured in both sizes.

// File: rtl/fdc_mode_pkg.sv
package fdc_mode_pkg;

    typedef enum logic [1:0] {
        MS_SD5 = 2'b00,
        MS_SD8 = 2'b01,
        MS_DD5 = 2'b10,
        MS_DD8 = 2'b11
    } mode_state_e;

    localparam int DRV_STEP  = 0;
    localparam int DRV_DIR   = 1;
    localparam int DRV_WDATA = 2;
    localparam int DRV_WGATE = 3;

endpackage

// File: rtl/fdc_mode_fsm.sv
module fdc_mode_fsm
    import fdc_mode_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                DATA_W       = 8,
    parameter logic [ADDR_W-1:0] DEN_ADDR     = 16'h37EC,
    parameter logic [ADDR_W-1:0] SIZE_ADDR    = 16'h37EE,
    parameter logic [DATA_W-1:0] SD_CODE      = 8'hFE,
    parameter logic [DATA_W-1:0] DD_CODE      = 8'hFF,
    parameter int                SIZE_CMD_BIT = 7,
    parameter int                SIZE_8_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              size_sw,
    output logic              is_double,
    output logic              is_five
);

    mode_state_e state_q, state_d;
    logic hit_den, hit_size;
    logic ev_sd, ev_dd, ev_s5, ev_s8;

    always_comb begin
        hit_den  = bus_wr && (bus_addr == DEN_ADDR);
        hit_size = bus_wr && (bus_addr == SIZE_ADDR) && bus_wdata[SIZE_CMD_BIT];
        ev_sd    = hit_den && (bus_wdata == SD_CODE);
        ev_dd    = hit_den && (bus_wdata == DD_CODE);
        ev_s8    = hit_size && bus_wdata[SIZE_8_BIT];
        ev_s5    = hit_size && !bus_wdata[SIZE_8_BIT];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_SD5: begin
                if (ev_dd)      state_d = MS_DD5;
                else if (ev_s8) state_d = MS_SD8;
            end
            MS_SD8: begin
                if (ev_dd)      state_d = MS_DD8;
                else if (ev_s5) state_d = MS_SD5;
            end
            MS_DD5: begin
                if (ev_sd)      state_d = MS_SD5;
                else if (ev_s8) state_d = MS_DD8;
            end
            MS_DD8: begin
                if (ev_sd)      state_d = MS_SD8;
                else if (ev_s5) state_d = MS_DD5;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= size_sw ? MS_SD5 : MS_SD8;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MS_SD5: begin is_double = 1'b0; is_five = 1'b1; end
            MS_SD8: begin is_double = 1'b0; is_five = 1'b0; end
            MS_DD5: begin is_double = 1'b1; is_five = 1'b1; end
            MS_DD8: begin is_double = 1'b1; is_five = 1'b0; end
        endcase
    end

    // R2
    dd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DEN_ADDR && bus_wdata == DD_CODE) |=> is_double);
    // R2
    sd_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DEN_ADDR && bus_wdata == SD_CODE) |=> !is_double);
    // R3
    den_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == DEN_ADDR && (bus_wdata == SD_CODE || bus_wdata == DD_CODE))
        |=> $stable(is_double));
    // R6
    size8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SIZE_ADDR && bus_wdata[SIZE_CMD_BIT] && bus_wdata[SIZE_8_BIT])
        |=> !is_five);
    // R6
    size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == SIZE_ADDR && bus_wdata[SIZE_CMD_BIT]) |=> $stable(is_five));

endmodule

// File: rtl/fdc_clk_div.sv
module fdc_clk_div (
    input  logic clk,
    input  logic rst_n,
    input  logic is_five,
    output logic ctl_clk,
    output logic ctl_clk_en
);

    logic half_q;
    logic ctl_q;
    logic sel_en;

    always_comb sel_en = is_five ? half_q : 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            ctl_q  <= 1'b0;
        end else begin
            half_q <= !half_q;
            if (sel_en) ctl_q <= !ctl_q;
        end
    end

    always_comb begin
        ctl_clk    = ctl_q;
        ctl_clk_en = sel_en && ctl_q;
    end

    // R7
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clk_en |=> !ctl_clk_en);
    // R7
    strobe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clk_en |=> !ctl_clk);

endmodule

// File: rtl/fdc_steer.sv
module fdc_steer #(
    parameter int DRV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_double,
    input  logic             is_five,
    input  logic [DRV_W-1:0] sd_drv,
    input  logic [DRV_W-1:0] dd_drv,
    input  logic             sd_tg43,
    input  logic             dd_tg43,
    output logic             sd_core_en,
    output logic             dd_core_en,
    output logic [DRV_W-1:0] drv_out,
    output logic             tg43_out,
    output logic             precomp_en
);

    logic core_tg43;

    always_comb begin
        sd_core_en = !is_double;
        dd_core_en = is_double;
        core_tg43  = is_double ? dd_tg43 : sd_tg43;
        tg43_out   = is_five ? 1'b1 : core_tg43;
        precomp_en = is_double && tg43_out;
    end

    for (genvar b = 0; b < DRV_W; b++) begin : g_drv
        always_comb drv_out[b] = is_double ? dd_drv[b] : sd_drv[b];
    end

    // R4
    one_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sd_core_en, dd_core_en}) == 1);
    // R9
    precomp_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_core_en |-> !precomp_en);
    // R8
    tg43_five_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_five && dd_core_en) |-> precomp_en);

endmodule

// File: rtl/fdc_mode_ctl.sv
module fdc_mode_ctl
    import fdc_mode_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                DRV_W     = 4,
    parameter logic [ADDR_W-1:0] DEN_ADDR  = 16'h37EC,
    parameter logic [ADDR_W-1:0] SIZE_ADDR = 16'h37EE,
    parameter logic [DATA_W-1:0] SD_CODE   = 8'hFE,
    parameter logic [DATA_W-1:0] DD_CODE   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              size_sw,
    input  logic [DRV_W-1:0]  sd_drv,
    input  logic [DRV_W-1:0]  dd_drv,
    input  logic              sd_tg43,
    input  logic              dd_tg43,
    output logic              sd_core_en,
    output logic              dd_core_en,
    output logic [DRV_W-1:0]  drv_out,
    output logic              tg43_out,
    output logic              precomp_en,
    output logic              ctl_clk,
    output logic              ctl_clk_en
);

    localparam int CMD_BIT = DATA_W - 1;
    localparam int BIG_BIT = DATA_W - 2;

    logic is_double;
    logic is_five;

    fdc_mode_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .DEN_ADDR(DEN_ADDR), .SIZE_ADDR(SIZE_ADDR),
        .SD_CODE(SD_CODE), .DD_CODE(DD_CODE),
        .SIZE_CMD_BIT(CMD_BIT), .SIZE_8_BIT(BIG_BIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .size_sw(size_sw),
        .is_double(is_double), .is_five(is_five)
    );

    fdc_clk_div u_div (
        .clk(clk), .rst_n(rst_n), .is_five(is_five),
        .ctl_clk(ctl_clk), .ctl_clk_en(ctl_clk_en)
    );

    fdc_steer #(.DRV_W(DRV_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .is_double(is_double), .is_five(is_five),
        .sd_drv(sd_drv), .dd_drv(dd_drv), .sd_tg43(sd_tg43), .dd_tg43(dd_tg43),
        .sd_core_en(sd_core_en), .dd_core_en(dd_core_en), .drv_out(drv_out),
        .tg43_out(tg43_out), .precomp_en(precomp_en)
    );

    // R8
    tg43_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_five && sd_core_en) |-> (tg43_out == sd_tg43));

endmodule

// File: tb/tb_fdc_mode_ctl.sv
module tb_fdc_mode_ctl;

    localparam logic [15:0] A_DEN  = 16'h37EC;
    localparam logic [15:0] A_SIZE = 16'h37EE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        size_sw = 1'b1;
    logic [3:0]  sd_drv = '0, dd_drv = '0;
    logic        sd_tg43 = 1'b0, dd_tg43 = 1'b0;
    logic        sd_core_en, dd_core_en, tg43_out, precomp_en, ctl_clk, ctl_clk_en;
    logic [3:0]  drv_out;

    int n_chk = 0;
    int n_fail = 0;
    bit m_dd = 0;
    bit m_five = 1;

    fdc_mode_ctl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .size_sw(size_sw), .sd_drv(sd_drv), .dd_drv(dd_drv),
        .sd_tg43(sd_tg43), .dd_tg43(dd_tg43), .sd_core_en(sd_core_en),
        .dd_core_en(dd_core_en), .drv_out(drv_out), .tg43_out(tg43_out),
        .precomp_en(precomp_en), .ctl_clk(ctl_clk), .ctl_clk_en(ctl_clk_en)
    );

    always #4 clk = !clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_tg43();
        return m_five ? 1'b1 : (m_dd ? dd_tg43 : sd_tg43);
    endfunction

    function automatic bit exp_precomp();
        return m_dd && (m_five || dd_tg43);
    endfunction

    task automatic check_outs();
        chk(sd_core_en == !m_dd && dd_core_en == m_dd, "R4 core enables",
            {sd_core_en, dd_core_en}, {!m_dd, m_dd});
        chk(drv_out == (m_dd ? dd_drv : sd_drv), "R5 drive steering",
            drv_out, m_dd ? dd_drv : sd_drv);
        chk(tg43_out == exp_tg43(), "R8 track43", tg43_out, exp_tg43());
        chk(precomp_en == exp_precomp(), "R9 precomp", precomp_en, exp_precomp());
    endtask

    task automatic cyc(input bit wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        sd_drv = 4'($urandom); dd_drv = 4'($urandom);
        sd_tg43 = 1'($urandom); dd_tg43 = 1'($urandom);
        size_sw = 1'($urandom);
        @(posedge clk);
        if (wr && a == A_DEN && d == 8'hFF) m_dd = 1;
        if (wr && a == A_DEN && d == 8'hFE) m_dd = 0;
        if (wr && a == A_SIZE && d[7]) m_five = !d[6];
        #2;
        check_outs();
    endtask

    task automatic do_reset(input bit sw);
        @(negedge clk);
        rst_n = 0; size_sw = sw; bus_wr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_dd = 0; m_five = sw;
        sd_tg43 = 0; dd_tg43 = 1;
        #1;
        chk(sd_core_en == 1 && dd_core_en == 0, "R1 reset density", sd_core_en, 1);
        chk(tg43_out == sw, "R1 reset size", tg43_out, sw);
    endtask

    task automatic measure(input int gap, input string req);
        int last;
        int high_cnt;
        @(negedge clk);
        bus_wr = 0;
        repeat (8) @(negedge clk);
        last = -1; high_cnt = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (ctl_clk) high_cnt++;
            if (ctl_clk_en) begin
                chk(ctl_clk == 1, req, ctl_clk, 1);
                if (last >= 0) chk(i - last == gap, req, i - last, gap);
                last = i;
            end
        end
        chk(high_cnt == 12, req, high_cnt, 12);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 both switch positions
        do_reset(1'b0);
        cyc(0, 16'h0, 8'h0);
        do_reset(1'b1);
        cyc(0, 16'h0, 8'h0);
        // R7 5.25-inch strobe
        measure(4, "R7 strobe 5.25");
        // R2 / R3 directed
        cyc(1, A_DEN, 8'hFF);
        chk(dd_core_en == 1, "R2 select double", dd_core_en, 1);
        cyc(1, A_DEN, 8'hFD);
        chk(dd_core_en == 1, "R3 other code ignored", dd_core_en, 1);
        cyc(1, 16'h37ED, 8'hFE);
        chk(dd_core_en == 1, "R3 other address ignored", dd_core_en, 1);
        cyc(1, A_DEN, 8'hFE);
        chk(sd_core_en == 1, "R2 select single", sd_core_en, 1);
        // R6 directed
        cyc(1, A_SIZE, 8'hC0);
        chk(m_five == 0, "R6 select 8 model", m_five, 0);
        cyc(1, A_SIZE, 8'h7F);
        cyc(1, A_SIZE, 8'h40);
        measure(2, "R7 strobe 8");
        cyc(1, A_SIZE, 8'h80);
        cyc(0, 16'h0, 8'h0);
        measure(4, "R6 back to 5.25 strobe");
        cyc(1, A_SIZE, 8'hC0);
        cyc(1, A_DEN, 8'hFF);
        measure(2, "R6 density keeps size");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [15:0] a;
            logic [7:0] d;
            sel = int'($urandom_range(0, 2));
            a = (sel == 0) ? A_DEN : (sel == 1) ? A_SIZE : 16'($urandom);
            d = ($urandom_range(0, 1) == 1) ? (8'hFE | 8'($urandom_range(0, 1))) : 8'($urandom);
            cyc(1'($urandom), a, d);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule